// File: doc/BRIEF.md
# Ethernet Controller Interrupt Status Unit

This block gathers the event flags of a simple Ethernet controller into byte-wide registers that a host reads over a small register bus. The MAC core sends single-cycle event pulses for the transmit and receive directions and for DMA completion. Each pulse sets a sticky flag. The host reads a direction's flags at that direction's status offset. It clears them by writing ones to the same offset. Each direction also has a mask register. A 1 in a mask bit lets the matching flag raise an interrupt.

A combined interrupt byte is driven to the host at all times. Its summary bits are active low: a 0 means that an unmasked event of that kind is waiting. Some transmit status positions are not sticky flags. They show live line conditions, and a read-only field shows the current collision count. A separate register bit holds the MAC core in reset for as long as the host leaves it set.

Top module: `eth_irq_status`

## Requirements
- R1: A pulse on a transmit event input sets the flag at the same bit position, for bits 7, 5, 3, 2, 1 and 0. The flag reads back at offset 0 from the cycle after the pulse. Pulses on event bits 6 and 4 latch nothing.
- R2: Transmit status bit 6 shows the carrier-sense input and bit 4 shows the shorted-medium input, both live and unlatched.
- R3: A pulse on a receive event input sets the flag at bit 7, 4, 3, 2, 1 or 0, read at offset 2. Bits 6 and 5 at offset 2 always read 0.
- R4: A write to offset 0 or offset 2 clears every flag of that direction whose data bit is 1. Flags whose data bit is 0 keep their value.
- R5: The transmit mask at offset 1 and the receive mask at offset 3 are read/write. Only the positions that have a sticky flag can be stored, and the other positions read 0.
- R6: Bit 0 of the combined interrupt byte is 0 exactly when some transmit flag and its mask bit are both 1.
- R7: Bit 1 of the combined interrupt byte is 0 exactly when some receive flag and its mask bit are both 1.
- R8: When an event pulse and a clearing write hit the same flag in one cycle, the flag ends up set.
- R9: A DMA-done pulse makes bit 2 of the combined byte read 0. Writing the combined byte's offset 7 with data bit 2 set returns bit 2 to 1. Bits 7 to 3 of the combined byte read 0, and the byte can also be read at offset 7.
- R10: Writing offset 6 with bit 7 set holds the MAC core reset output high until offset 6 is written with bit 7 clear. Offset 6 reads back the held bit in position 7.
- R11: Offset 4 shows the live collision count in bits 7 to 4 and reads 0 in bits 3 to 0.
- R12: The global reset clears every flag, every mask bit and the core-reset bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Global reset, active low |
| tx_evt_i | input | 8 | Transmit event pulses, one per status position |
| rx_evt_i | input | 8 | Receive event pulses, one per status position |
| dma_done_i | input | 1 | DMA completion pulse |
| carrier_i | input | 1 | Live carrier-sense level |
| short_i | input | 1 | Live shorted-medium level |
| col_cnt_i | input | 4 | Live collision count since the last success |
| addr_i | input | ADDR_W | Register offset |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for the offset on addr_i |
| irq_stat_o | output | 8 | Combined interrupt byte, summary bits active low |
| mac_rst_o | output | 1 | Holds the MAC core in reset |

## Verification
The properties assume that every event input is a single-cycle pulse applied between clock edges. They also assume that a write presents its offset and data for exactly the cycle its strobe is high. The stimulus drives every input on the falling edge and drops each pulse and strobe again one cycle later. The only case where a clearing write and an event meet is a deliberate collision on a single flag. The live inputs are changed only while no read is being compared, so every expected value is fixed before it is sampled.

// File: rtl/eth_irq_pkg.sv
package eth_irq_pkg;
   // register offsets on the host bus
   localparam int OFF_TX_STAT  = 0;
   localparam int OFF_TX_MASK  = 1;
   localparam int OFF_RX_STAT  = 2;
   localparam int OFF_RX_MASK  = 3;
   localparam int OFF_TX_MODE  = 4;
   localparam int OFF_CORE_RST = 6;
   localparam int OFF_IRQ      = 7;

   // positions holding sticky flags
   localparam logic [7:0] TX_STICKY = 8'hAF;
   localparam logic [7:0] RX_STICKY = 8'h9F;
   // positions showing live levels
   localparam logic [7:0] TX_LIVE   = 8'h50;
   localparam logic [7:0] NO_LIVE   = 8'h00;

   localparam int BIT_CARRIER  = 6;
   localparam int BIT_SHORT    = 4;
   localparam int BIT_CORE_RST = 7;
   localparam int BIT_DMA      = 2;
endpackage

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
   parameter int          W        = 8,
   parameter logic [W-1:0] STICKY  = '1,
   parameter logic [W-1:0] LIVE    = '0,
   parameter bit          EVT_WINS = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] evt_i,
   input  logic [W-1:0] live_i,
   input  logic         clr_we_i,
   input  logic [W-1:0] clr_i,
   output logic [W-1:0] lat_o,
   output logic [W-1:0] view_o
);
   logic [W-1:0] clr_v;
   logic [W-1:0] lat_q;
   logic [W-1:0] lat_d;

   if ((STICKY & LIVE) != '0) begin : g_overlap
      $error("irq_flag_bank: a position cannot be both sticky and live");
   end

   assign clr_v = clr_we_i ? clr_i : '0;

   if (EVT_WINS) begin : g_evt_wins
      assign lat_d = ((lat_q & ~clr_v) | evt_i) & STICKY;
   end else begin : g_clr_wins
      assign lat_d = ((lat_q | evt_i) & ~clr_v) & STICKY;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lat_q <= '0;
      else        lat_q <= lat_d;
   end

   assign lat_o  = lat_q;
   assign view_o = lat_q | (live_i & LIVE);
endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
   parameter int           W     = 8,
   parameter logic [W-1:0] VALID = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         we_i,
   input  logic [W-1:0] wdata_i,
   output logic [W-1:0] msk_o
);
   logic [W-1:0] msk_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    msk_q <= '0;
      else if (we_i) msk_q <= wdata_i & VALID;
   end

   assign msk_o = msk_q;
endmodule

// File: rtl/irq_pend_n.sv
module irq_pend_n #(
   parameter int W = 8
) (
   input  logic [W-1:0] lat_i,
   input  logic [W-1:0] msk_i,
   output logic         pend_n_o
);
   assign pend_n_o = ~|(lat_i & msk_i);
endmodule

// File: rtl/eth_irq_status.sv
module eth_irq_status
   import eth_irq_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int ADDR_W = 3,
   parameter int CNT_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] tx_evt_i,
   input  logic [DATA_W-1:0] rx_evt_i,
   input  logic              dma_done_i,
   input  logic              carrier_i,
   input  logic              short_i,
   input  logic [CNT_W-1:0]  col_cnt_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              wr_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic [DATA_W-1:0] rdata_o,
   output logic [DATA_W-1:0] irq_stat_o,
   output logic              mac_rst_o
);
   localparam int PAD_W = DATA_W - CNT_W;

   if (DATA_W != 8) begin : g_bad_data
      $error("eth_irq_status: DATA_W must be 8");
   end
   if (ADDR_W < 3) begin : g_bad_addr
      $error("eth_irq_status: ADDR_W must reach offset 7");
   end
   if (CNT_W > DATA_W) begin : g_bad_cnt
      $error("eth_irq_status: CNT_W wider than data");
   end

   logic              sel_tx_stat, sel_tx_mask, sel_rx_stat, sel_rx_mask;
   logic              sel_core_rst, sel_irq;
   logic [DATA_W-1:0] tx_live;
   logic [DATA_W-1:0] tx_lat_q, tx_view, tx_msk_q;
   logic [DATA_W-1:0] rx_lat_q, rx_view, rx_msk_q;
   logic [0:0]        dma_lat, dma_view;
   logic              dma_pend_q;
   logic              tx_pend_n, rx_pend_n;
   logic              core_rst_q;

   assign sel_tx_stat  = (addr_i == ADDR_W'(OFF_TX_STAT));
   assign sel_tx_mask  = (addr_i == ADDR_W'(OFF_TX_MASK));
   assign sel_rx_stat  = (addr_i == ADDR_W'(OFF_RX_STAT));
   assign sel_rx_mask  = (addr_i == ADDR_W'(OFF_RX_MASK));
   assign sel_core_rst = (addr_i == ADDR_W'(OFF_CORE_RST));
   assign sel_irq      = (addr_i == ADDR_W'(OFF_IRQ));

   always_comb begin
      tx_live              = '0;
      tx_live[BIT_CARRIER] = carrier_i;
      tx_live[BIT_SHORT]   = short_i;
   end

   irq_flag_bank #(.W(DATA_W), .STICKY(TX_STICKY), .LIVE(TX_LIVE)) u_tx_flags (
      .clk(clk), .rst_n(rst_n), .evt_i(tx_evt_i), .live_i(tx_live),
      .clr_we_i(wr_i & sel_tx_stat), .clr_i(wdata_i),
      .lat_o(tx_lat_q), .view_o(tx_view));

   irq_flag_bank #(.W(DATA_W), .STICKY(RX_STICKY), .LIVE(NO_LIVE)) u_rx_flags (
      .clk(clk), .rst_n(rst_n), .evt_i(rx_evt_i), .live_i('0),
      .clr_we_i(wr_i & sel_rx_stat), .clr_i(wdata_i),
      .lat_o(rx_lat_q), .view_o(rx_view));

   irq_flag_bank #(.W(1), .STICKY(1'b1), .LIVE(1'b0)) u_dma_flag (
      .clk(clk), .rst_n(rst_n), .evt_i(dma_done_i), .live_i(1'b0),
      .clr_we_i(wr_i & sel_irq), .clr_i(wdata_i[BIT_DMA]),
      .lat_o(dma_lat), .view_o(dma_view));

   assign dma_pend_q = dma_view[0];

   irq_mask_reg #(.W(DATA_W), .VALID(TX_STICKY)) u_tx_mask (
      .clk(clk), .rst_n(rst_n), .we_i(wr_i & sel_tx_mask),
      .wdata_i(wdata_i), .msk_o(tx_msk_q));

   irq_mask_reg #(.W(DATA_W), .VALID(RX_STICKY)) u_rx_mask (
      .clk(clk), .rst_n(rst_n), .we_i(wr_i & sel_rx_mask),
      .wdata_i(wdata_i), .msk_o(rx_msk_q));

   irq_pend_n #(.W(DATA_W)) u_tx_pend (
      .lat_i(tx_lat_q), .msk_i(tx_msk_q), .pend_n_o(tx_pend_n));

   irq_pend_n #(.W(DATA_W)) u_rx_pend (
      .lat_i(rx_lat_q), .msk_i(rx_msk_q), .pend_n_o(rx_pend_n));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    core_rst_q <= 1'b0;
      else if (wr_i && sel_core_rst) core_rst_q <= wdata_i[BIT_CORE_RST];
   end

   assign mac_rst_o = core_rst_q;

   always_comb begin
      irq_stat_o          = '0;
      irq_stat_o[0]       = tx_pend_n;
      irq_stat_o[1]       = rx_pend_n;
      irq_stat_o[BIT_DMA] = ~dma_lat[0];
   end

   always_comb begin
      rdata_o = '0;
      unique case (1'b1)
         sel_tx_stat:  rdata_o = tx_view;
         sel_tx_mask:  rdata_o = tx_msk_q;
         sel_rx_stat:  rdata_o = rx_view;
         sel_rx_mask:  rdata_o = rx_msk_q;
         (addr_i == ADDR_W'(OFF_TX_MODE)):
                       rdata_o = {col_cnt_i, {PAD_W{1'b0}}};
         sel_core_rst: rdata_o[BIT_CORE_RST] = core_rst_q;
         sel_irq:      rdata_o = irq_stat_o;
         default:      rdata_o = '0;
      endcase
   end
endmodule

// File: rtl/eth_irq_status_chk.sv
module eth_irq_status_chk
   import eth_irq_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int ADDR_W = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic [DATA_W-1:0] tx_evt_i,
   input logic [DATA_W-1:0] rx_evt_i,
   input logic              dma_done_i,
   input logic [ADDR_W-1:0] addr_i,
   input logic              wr_i,
   input logic [DATA_W-1:0] wdata_i,
   input logic [DATA_W-1:0] irq_stat_o,
   input logic              mac_rst_o,
   input logic [DATA_W-1:0] tx_lat_q,
   input logic [DATA_W-1:0] tx_msk_q,
   input logic [DATA_W-1:0] rx_lat_q,
   input logic [DATA_W-1:0] rx_msk_q
);
   // R1
   tx_evt_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_evt_i[7] |=> tx_lat_q[7]);

   // R3
   rx_evt_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_evt_i[0] |=> rx_lat_q[0]);

   // R4
   tx_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_i && addr_i == ADDR_W'(OFF_TX_STAT) && wdata_i[0] && !tx_evt_i[0])
      |=> !tx_lat_q[0]);

   // R5
   tx_mask_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_i && addr_i == ADDR_W'(OFF_TX_MASK))
      |=> tx_msk_q == ($past(wdata_i) & TX_STICKY));

   // R6
   tx_summary_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|(tx_lat_q & tx_msk_q)) |-> !irq_stat_o[0]);

   // R7
   rx_summary_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|(rx_lat_q & rx_msk_q)) |-> !irq_stat_o[1]);

   // R8
   evt_beats_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_i && addr_i == ADDR_W'(OFF_TX_STAT) && wdata_i[2] && tx_evt_i[2])
      |=> tx_lat_q[2]);

   // R9
   dma_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dma_done_i |=> !irq_stat_o[BIT_DMA]);

   // R10
   core_rst_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_i && addr_i == ADDR_W'(OFF_CORE_RST) && wdata_i[BIT_CORE_RST])
      |=> mac_rst_o);
endmodule

bind eth_irq_status eth_irq_status_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .tx_evt_i(tx_evt_i), .rx_evt_i(rx_evt_i),
   .dma_done_i(dma_done_i), .addr_i(addr_i), .wr_i(wr_i), .wdata_i(wdata_i),
   .irq_stat_o(irq_stat_o), .mac_rst_o(mac_rst_o), .tx_lat_q(tx_lat_q),
   .tx_msk_q(tx_msk_q), .rx_lat_q(rx_lat_q), .rx_msk_q(rx_msk_q));

// File: tb/eth_irq_status_test.sv
module eth_irq_status_test;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] tx_evt_i = '0;
   logic [7:0] rx_evt_i = '0;
   logic       dma_done_i = 1'b0;
   logic       carrier_i = 1'b0;
   logic       short_i = 1'b0;
   logic [3:0] col_cnt_i = '0;
   logic [2:0] addr_i = '0;
   logic       wr_i = 1'b0;
   logic [7:0] wdata_i = '0;
   logic [7:0] rdata_o;
   logic [7:0] irq_stat_o;
   logic       mac_rst_o;

   typedef struct {
      int         kind;   // 0 read data, 1 interrupt byte, 2 core reset
      logic [7:0] exp;
      string      req;
   } exp_t;

   exp_t q[$];
   int   n_tests = 0;
   int   n_fail  = 0;
   bit   ended   = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   eth_irq_status uut (
      .clk(clk), .rst_n(rst_n), .tx_evt_i(tx_evt_i), .rx_evt_i(rx_evt_i),
      .dma_done_i(dma_done_i), .carrier_i(carrier_i), .short_i(short_i),
      .col_cnt_i(col_cnt_i), .addr_i(addr_i), .wr_i(wr_i), .wdata_i(wdata_i),
      .rdata_o(rdata_o), .irq_stat_o(irq_stat_o), .mac_rst_o(mac_rst_o));

   // monitor: compares one queued item shortly after each falling edge
   initial begin
      forever begin
         @(negedge clk);
         #1;
         if (q.size() > 0) begin
            exp_t e;
            logic [7:0] act;
            e = q.pop_front();
            act = (e.kind == 0) ? rdata_o : (e.kind == 1) ? irq_stat_o : {7'b0, mac_rst_o};
            n_tests++;
            if (act !== e.exp) begin
               n_fail++;
               $display("FAIL %s kind=%0d actual=%02h expected=%02h", e.req, e.kind, act, e.exp);
            end
         end
      end
   end

   task automatic expect_item(input int kind, input logic [2:0] a, input logic [7:0] e, input string req);
      exp_t it;
      @(negedge clk);
      addr_i = a;
      it.kind = kind; it.exp = e; it.req = req;
      q.push_back(it);
      @(posedge clk);
   endtask

   task automatic rd(input logic [2:0] a, input logic [7:0] e, input string req);
      expect_item(0, a, e, req);
   endtask

   task automatic irq(input logic [7:0] e, input string req);
      expect_item(1, 3'd0, e, req);
   endtask

   task automatic cyc(input bit we, input logic [2:0] a, input logic [7:0] d,
                      input logic [7:0] te, input logic [7:0] re, input bit dma);
      @(negedge clk);
      wr_i = we; addr_i = a; wdata_i = d;
      tx_evt_i = te; rx_evt_i = re; dma_done_i = dma;
      @(posedge clk);
      #1;
      wr_i = 1'b0; tx_evt_i = '0; rx_evt_i = '0; dma_done_i = 1'b0;
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      cyc(1'b1, a, d, 8'h00, 8'h00, 1'b0);
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      if (!ended) begin
         ended = 1'b1;
         n_fail++;
         $display("FAIL watchdog expired");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R12 reset state
      rd(3'd0, 8'h00, "R12 tx status after reset");
      rd(3'd1, 8'h00, "R12 tx mask after reset");
      rd(3'd2, 8'h00, "R12 rx status after reset");
      rd(3'd3, 8'h00, "R12 rx mask after reset");
      irq(8'h07, "R12 interrupt byte after reset");
      expect_item(2, 3'd0, 8'h00, "R12 core reset low after reset");

      // R1 all transmit events, bits 6 and 4 not latched
      cyc(1'b0, 3'd0, 8'h00, 8'hFF, 8'h00, 1'b0);
      rd(3'd0, 8'hAF, "R1 tx flags latched");
      // R2 live levels
      @(negedge clk); carrier_i = 1'b1; short_i = 1'b1;
      rd(3'd0, 8'hFF, "R2 live carrier and short shown");
      @(negedge clk); carrier_i = 1'b0; short_i = 1'b0;
      rd(3'd0, 8'hAF, "R2 live levels drop");

      // R3 receive events, bits 6 and 5 read 0
      cyc(1'b0, 3'd0, 8'h00, 8'h00, 8'hFF, 1'b0);
      rd(3'd2, 8'h9F, "R3 rx flags latched");
      irq(8'h07, "R6 masked flags give no pending");

      // R4 write-one-to-clear, zeros leave flags
      wr(3'd0, 8'h81);
      rd(3'd0, 8'h2E, "R4 tx clear bits 7 and 0");
      wr(3'd0, 8'h00);
      rd(3'd0, 8'h2E, "R4 zero write keeps flags");

      // R5 masks, R6 transmit summary
      wr(3'd1, 8'hFF);
      rd(3'd1, 8'hAF, "R5 tx mask stores sticky positions");
      irq(8'h06, "R6 tx summary low");

      // R7 receive summary
      wr(3'd3, 8'h02);
      rd(3'd3, 8'h02, "R5 rx mask readback");
      irq(8'h04, "R7 rx summary low");
      wr(3'd2, 8'h02);
      rd(3'd2, 8'h9D, "R4 rx clear bit 1");
      irq(8'h06, "R7 rx summary back high");

      // R8 event beats clear on the same flag
      cyc(1'b1, 3'd0, 8'h04, 8'h04, 8'h00, 1'b0);
      rd(3'd0, 8'h2E, "R8 event wins over clear");
      wr(3'd0, 8'h2E);
      rd(3'd0, 8'h00, "R4 tx all cleared");
      irq(8'h07, "R6 tx summary high when cleared");

      // R9 DMA-done
      cyc(1'b0, 3'd0, 8'h00, 8'h00, 8'h00, 1'b1);
      irq(8'h03, "R9 dma pending low");
      wr(3'd7, 8'h00);
      rd(3'd7, 8'h03, "R9 zero write keeps dma pending");
      wr(3'd7, 8'h04);
      irq(8'h07, "R9 dma cleared");

      // R10 core reset hold
      wr(3'd6, 8'h80);
      expect_item(2, 3'd6, 8'h01, "R10 core held in reset");
      rd(3'd6, 8'h80, "R10 core reset readback");
      wr(3'd6, 8'h00);
      expect_item(2, 3'd0, 8'h00, "R10 core released");

      // R11 collision count
      @(negedge clk); col_cnt_i = 4'h5;
      rd(3'd4, 8'h50, "R11 collision count field");

      // R12 global reset mid-run
      cyc(1'b0, 3'd0, 8'h00, 8'h01, 8'h80, 1'b0);
      wr(3'd1, 8'h01);
      wr(3'd6, 8'h80);
      irq(8'h06, "R6 pending before reset");
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk); rst_n = 1'b1;
      rd(3'd0, 8'h00, "R12 tx flags cleared");
      rd(3'd1, 8'h00, "R12 tx mask cleared");
      rd(3'd2, 8'h00, "R12 rx flags cleared");
      irq(8'h07, "R12 interrupt byte idle");
      expect_item(2, 3'd0, 8'h00, "R12 core reset cleared");

      @(negedge clk);
      #3;
      if (!ended) begin
         ended = 1'b1;
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end
endmodule